// File: doc/BRIEF.md
# Setup Frame Perfect Address Filter

This block decides, for every received Ethernet frame, whether its destination address belongs to the station. It holds a table of sixteen 48-bit station addresses. The table is loaded from a 192-byte setup frame, which arrives as a stream of 32-bit words. Each address takes three consecutive words. Only the low half of each word carries address bytes, and the lower-numbered byte of each pair sits in bits 7:0. Slots that software leaves empty are filled with all-ones, so they match the broadcast address.

On the receive side the block takes destination bytes one per cycle, marked by a start-of-frame flag on the first byte. It compares the assembled address against all sixteen entries in parallel and reports the result one cycle after the sixth byte. A configuration input lets every group-addressed frame through, whatever the table holds.

A new table is staged in a shadow copy and committed in a single cycle, and only when the frame is exactly the right length. A malformed load is reported and leaves the working table untouched.

Top module: `setup_addr_filter`

## Requirements
- R1: After reset the outputs ldDone, ldErr and matchValid are 0, and every table entry holds all-ones: the broadcast address is accepted and a unicast address is rejected.
- R2: A load of exactly NUM_ENTRIES*3 words (48 by default), with ldLast on the final word, raises ldDone for one cycle, starting in the cycle after the final word, with ldErr low. The new table is in use from the cycle after that.
- R3: In load word 3*e+p (p = 0, 1, 2), bits 7:0 carry address byte 2p of entry e and bits 15:8 carry byte 2p+1. Bits 31:16 are ignored.
- R4: When the six destination bytes (byte 0 first) equal any table entry, matchAccept is 1. When they equal none, and the multicast pass-through (R6) does not apply, matchAccept is 0.
- R5: matchValid is a single-cycle pulse in the cycle after the sixth destination byte. Further bytes of the same frame produce no further pulse.
- R6: With cfgPassMcast = 1, a destination whose byte 0 bit 0 is 1 is accepted even with no table match. With cfgPassMcast = 0, such a destination is accepted only by a table match.
- R7: A load whose ldLast word is not word number NUM_ENTRIES*3 (too short or too long) raises ldErr for one cycle after the final word, does not raise ldDone, and leaves the working table unchanged.
- R8: A table entry loaded as all-ones matches the broadcast address FF:FF:FF:FF:FF:FF. Once every entry holds a unicast address, broadcast is rejected.
- R9: A byte with rxSof = 1 restarts address assembly as byte 0. Cycles with rxValid = 0 neither advance assembly nor produce a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPassMcast | input | 1 | Accept every group-addressed destination |
| ldValid | input | 1 | Setup-frame word valid |
| ldData | input | WORD_W | Setup-frame word |
| ldLast | input | 1 | Final word of the setup frame |
| ldDone | output | 1 | Pulse: table committed |
| ldErr | output | 1 | Pulse: setup frame length wrong, table kept |
| rxValid | input | 1 | Destination byte valid |
| rxSof | input | 1 | This byte is byte 0 of a new frame |
| rxByte | input | 8 | Received byte |
| matchValid | output | 1 | Pulse: filter decision available |
| matchAccept | output | 1 | Filter decision, 1 = accept |

## Verification
The bench builds the block with its defaults: NUM_ENTRIES = 16 and WORD_W = 32. This makes a full 192-byte frame the only valid load, so both off-by-one lengths, 47 and 49 words, can be tried against it. With sixteen entries the bench sweeps every entry and, for each one, a copy with each of the six bytes perturbed. It does this under two different tables, one of which leaves a slot empty, and it repeats the group-bit cases with the pass-through enabled and disabled.

// File: rtl/setup_filter_pkg.sv
package setup_filter_pkg;

  localparam int ADDR_BYTES      = 6;
  localparam int ADDR_W          = ADDR_BYTES * 8;
  localparam int HALF_W          = 16;
  localparam int WORDS_PER_ENTRY = ADDR_W / HALF_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic       ldWrite;    // write one half-word into the shadow table
    logic [1:0] ldPart;     // which third of the entry
    logic       commit;     // copy shadow table into working table
    logic       rxCapture;  // store rxByte at rxIdx
    logic [2:0] rxIdx;      // destination byte index
    logic       rxEval;     // sixth byte present: evaluate now
  } filtStrobes_t;

endpackage

// File: rtl/setup_filter_ctrl.sv
module setup_filter_ctrl
  import setup_filter_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           ldValid,
  input  logic                           ldLast,
  input  logic                           rxValid,
  input  logic                           rxSof,
  output filtStrobes_t                   strb,
  output logic [$clog2(NUM_ENTRIES)-1:0] ldEntry,
  output logic                           ldDone,
  output logic                           ldErr
);

  localparam int FRAME_WORDS = NUM_ENTRIES * WORDS_PER_ENTRY;
  localparam int CNT_W       = $clog2(FRAME_WORDS);
  localparam int ENTRY_W     = $clog2(NUM_ENTRIES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_WORDS - 1);
  localparam logic [2:0] RX_IDLE  = 3'(ADDR_BYTES);
  localparam logic [2:0] RX_FINAL = 3'(ADDR_BYTES - 1);

  logic [CNT_W-1:0]   wordCnt;
  logic [1:0]         partQ;
  logic [ENTRY_W-1:0] entryQ;
  logic               tooLong;
  logic               doneQ;
  logic               errQ;
  logic               lenOk;
  logic [2:0]         rxCnt;

  assign lenOk = (wordCnt == LAST_IDX) && !tooLong;

  // Setup-frame word tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt <= '0;
      partQ   <= '0;
      entryQ  <= '0;
      tooLong <= 1'b0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      if (ldValid) begin
        if (ldLast) begin
          wordCnt <= '0;
          partQ   <= '0;
          entryQ  <= '0;
          tooLong <= 1'b0;
          doneQ   <= lenOk;
          errQ    <= !lenOk;
        end else if (wordCnt == LAST_IDX) begin
          tooLong <= 1'b1;
        end else begin
          wordCnt <= wordCnt + 1'b1;
          if (partQ == 2'd2) begin
            partQ  <= '0;
            entryQ <= entryQ + 1'b1;
          end else begin
            partQ <= partQ + 1'b1;
          end
        end
      end
    end
  end

  // Destination byte tracking; RX_IDLE means not inside an address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCnt <= RX_IDLE;
    end else if (rxValid) begin
      if (rxSof)                rxCnt <= 3'd1;
      else if (rxCnt != RX_IDLE) rxCnt <= rxCnt + 1'b1;
    end
  end

  always_comb begin
    strb           = '0;
    strb.ldWrite   = ldValid && !tooLong;
    strb.ldPart    = partQ;
    strb.commit    = doneQ;
    strb.rxCapture = rxValid && (rxSof || (rxCnt != RX_IDLE));
    strb.rxIdx     = rxSof ? 3'd0 : rxCnt;
    strb.rxEval    = rxValid && !rxSof && (rxCnt == RX_FINAL);
  end

  assign ldEntry = entryQ;
  assign ldDone  = doneQ;
  assign ldErr   = errQ;

  // R2: a commit only follows a final load word
  assert_done_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> $past(ldValid && ldLast));

  // R7: an overlong frame always ends in an error
  assert_long_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && ldLast && tooLong) |=> (errQ && !doneQ));

  // R9: byte counter stays in range
  assert_rxcnt_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxCnt <= RX_IDLE);

endmodule

// File: rtl/setup_filter_datapath.sv
module setup_filter_datapath
  import setup_filter_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int WORD_W      = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  filtStrobes_t                   strb,
  input  logic [$clog2(NUM_ENTRIES)-1:0] ldEntry,
  input  logic [WORD_W-1:0]              ldData,
  input  logic [7:0]                     rxByte,
  input  logic                           passMcast,
  output logic                           matchValid,
  output logic                           matchAccept
);

  localparam int ENTRY_W = $clog2(NUM_ENTRIES);
  localparam int HOLD_W  = ADDR_W - 8;

  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] shadowTbl;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] activeTbl;
  logic [NUM_ENTRIES-1:0]             hit;
  logic [HOLD_W-1:0]                  destQ;
  logic [ADDR_W-1:0]                  cmpAddr;
  logic                               accept;
  logic                               unusedUpper;

  assign unusedUpper = ^ldData[WORD_W-1:HALF_W];

  // Destination bytes 0..4 are held; byte 5 is compared straight from input
  always_ff @(posedge clk) begin
    if (!rstN) begin
      destQ <= '0;
    end else if (strb.rxCapture && (strb.rxIdx < 3'(ADDR_BYTES - 1))) begin
      destQ[int'(strb.rxIdx)*8 +: 8] <= rxByte;
    end
  end

  assign cmpAddr = {rxByte, destQ};

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowTbl[i] <= '1;
      end else if (strb.ldWrite && (ldEntry == ENTRY_W'(i))) begin
        shadowTbl[i][int'(strb.ldPart)*HALF_W +: HALF_W] <= ldData[HALF_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)            activeTbl[i] <= '1;
      else if (strb.commit) activeTbl[i] <= shadowTbl[i];
    end

    assign hit[i] = (activeTbl[i] == cmpAddr);
  end

  assign accept = (|hit) || (passMcast && destQ[0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchValid  <= 1'b0;
      matchAccept <= 1'b0;
    end else begin
      matchValid <= strb.rxEval;
      if (strb.rxEval) matchAccept <= accept;
    end
  end

  // R5: decision is a single-cycle pulse
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |=> !matchValid);

  // R7: working table moves only on commit
  assert_table_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(activeTbl));

  // R6: group destinations pass when pass-through is on
  assert_mcast_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxEval && passMcast && destQ[0]) |=> matchAccept);

endmodule

// File: rtl/setup_addr_filter.sv
module setup_addr_filter
  import setup_filter_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int WORD_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgPassMcast,
  input  logic              ldValid,
  input  logic [WORD_W-1:0] ldData,
  input  logic              ldLast,
  output logic              ldDone,
  output logic              ldErr,
  input  logic              rxValid,
  input  logic              rxSof,
  input  logic [7:0]        rxByte,
  output logic              matchValid,
  output logic              matchAccept
);

  localparam int ENTRY_W = $clog2(NUM_ENTRIES);

  filtStrobes_t       strb;
  logic [ENTRY_W-1:0] ldEntry;

  setup_filter_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ldValid (ldValid),
    .ldLast  (ldLast),
    .rxValid (rxValid),
    .rxSof   (rxSof),
    .strb    (strb),
    .ldEntry (ldEntry),
    .ldDone  (ldDone),
    .ldErr   (ldErr)
  );

  setup_filter_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .WORD_W(WORD_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .ldEntry     (ldEntry),
    .ldData      (ldData),
    .rxByte      (rxByte),
    .passMcast   (cfgPassMcast),
    .matchValid  (matchValid),
    .matchAccept (matchAccept)
  );

endmodule

// File: tb/setup_addr_filter_test.sv
module setup_addr_filter_test;

  localparam int NENT = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgPassMcast = 1'b0;
  logic        ldValid = 1'b0;
  logic [31:0] ldData = '0;
  logic        ldLast = 1'b0;
  logic        ldDone;
  logic        ldErr;
  logic        rxValid = 1'b0;
  logic        rxSof = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        matchValid;
  logic        matchAccept;

  int vectors = 0;
  int miscompares = 0;
  logic [47:0] modelTbl [NENT];

  always #2.5 clk = ~clk;

  setup_addr_filter uut (
    .clk(clk), .rstN(rstN), .cfgPassMcast(cfgPassMcast),
    .ldValid(ldValid), .ldData(ldData), .ldLast(ldLast),
    .ldDone(ldDone), .ldErr(ldErr),
    .rxValid(rxValid), .rxSof(rxSof), .rxByte(rxByte),
    .matchValid(matchValid), .matchAccept(matchAccept)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] entryAddr(input int variant, input int idx);
    logic [47:0] a;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b;
      b = {4'(idx), 3'(k), 1'b0};
      if (variant == 1 && k == 5) b = b ^ 8'h80;
      a[8*k +: 8] = b;
    end
    return a;
  endfunction

  // R3 packing: word 3e+p low half = {byte 2p+1, byte 2p}, upper half junk
  function automatic logic [31:0] frameWord(input int w, input int variant, input int nUsed);
    int e = w / 3;
    int p = w % 3;
    logic [47:0] a;
    if (e >= nUsed) return 32'hFFFF_FFFF;
    a = entryAddr(variant, e);
    return {16'hA5C3, a[16*p +: 16]};
  endfunction

  function automatic bit expAccept(input logic [47:0] a);
    bit r = 1'b0;
    for (int i = 0; i < NENT; i++) if (modelTbl[i] == a) r = 1'b1;
    if (cfgPassMcast && a[0]) r = 1'b1;
    return r;
  endfunction

  task automatic loadFrame(input int nWords, input int variant, input int nUsed);
    bit good = (nWords == NENT * 3);
    for (int w = 0; w < nWords; w++) begin
      @(negedge clk);
      ldValid = 1'b1;
      ldData  = frameWord(w, variant, nUsed);
      ldLast  = (w == nWords - 1);
      @(posedge clk); #1;
      if (w < nWords - 1) check(ldDone == 1'b0 && ldErr == 1'b0, "R2 no early pulse", {ldDone, ldErr}, 0);
    end
    if (good) begin
      check(ldDone == 1'b1, "R2 ldDone", ldDone, 1);
      check(ldErr == 1'b0, "R2 ldErr", ldErr, 0);
    end else begin
      check(ldErr == 1'b1, "R7 ldErr", ldErr, 1);
      check(ldDone == 1'b0, "R7 ldDone", ldDone, 0);
    end
    @(negedge clk);
    ldValid = 1'b0;
    ldLast  = 1'b0;
    @(posedge clk); #1;
    check(ldDone == 1'b0 && ldErr == 1'b0, "R2 single pulse", {ldDone, ldErr}, 0);
    if (good)
      for (int i = 0; i < NENT; i++) modelTbl[i] = (i < nUsed) ? entryAddr(variant, i) : '1;
  endtask

  task automatic runAddr(input logic [47:0] a, input bit gap, input string req);
    bit exp = expAccept(a);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rxValid = 1'b1;
      rxSof   = (k == 0);
      rxByte  = a[8*k +: 8];
      @(posedge clk); #1;
      if (k < 5) begin
        check(matchValid == 1'b0, "R5 early", matchValid, 0);
        if (gap) begin
          @(negedge clk);
          rxValid = 1'b0;
          rxByte  = 8'hEE;
          @(posedge clk); #1;
          check(matchValid == 1'b0, "R9 idle cycle", matchValid, 0);
        end
      end
    end
    check(matchValid == 1'b1, "R5 pulse", matchValid, 1);
    check(matchAccept == exp, req, matchAccept, exp);
    @(negedge clk);
    rxSof  = 1'b0;
    rxByte = 8'h55;
    @(posedge clk); #1;
    check(matchValid == 1'b0, "R5 trailing byte", matchValid, 0);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  initial begin
    #(50000 * 5);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < NENT; i++) modelTbl[i] = '1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check(ldDone == 0 && ldErr == 0 && matchValid == 0, "R1 reset outputs",
          {ldDone, ldErr, matchValid}, 0);
    runAddr(48'hFFFF_FFFF_FFFF, 1'b0, "R1 broadcast after reset");
    runAddr(entryAddr(0, 0), 1'b0, "R1 unicast after reset");

    // R2/R3: 15 entries used, last one left all-ones
    loadFrame(NENT * 3, 0, 15);
    for (int i = 0; i < NENT; i++) begin
      runAddr(modelTbl[i], 1'b0, (i == NENT - 1) ? "R8 empty slot" : "R4 entry hit");
      for (int k = 0; k < 6; k++)
        runAddr(modelTbl[i] ^ (48'h02 << (8 * k)), 1'b0, "R4 perturbed byte");
    end

    // R6: group bit sweep with pass-through off and on
    for (int m = 0; m < 2; m++) begin
      cfgPassMcast = m[0];
      for (int j = 0; j < 8; j++)
        runAddr({40'h3C_5A_69_96_C3, 8'(j * 16 + (j & 1))}, 1'b0, "R6 group bit");
      runAddr(modelTbl[4], 1'b0, "R6 table hit");
    end
    cfgPassMcast = 1'b0;

    // R9: aborted address then restart, with idle gaps
    @(negedge clk); rxValid = 1'b1; rxSof = 1'b1; rxByte = 8'h20;
    @(negedge clk); rxSof = 1'b0; rxByte = 8'h22;
    @(negedge clk); rxByte = 8'h24;
    @(negedge clk); rxValid = 1'b0;
    @(posedge clk); #1;
    check(matchValid == 1'b0, "R9 aborted address", matchValid, 0);
    runAddr(modelTbl[2], 1'b1, "R9 restart with gaps");

    // R7: short and long frames leave the table alone
    loadFrame(NENT * 3 - 1, 1, NENT);
    runAddr(modelTbl[3], 1'b0, "R7 old entry after short");
    runAddr(entryAddr(1, 0), 1'b0, "R7 new entry absent after short");
    loadFrame(NENT * 3 + 1, 1, NENT);
    runAddr(modelTbl[3], 1'b0, "R7 old entry after long");
    runAddr(entryAddr(1, 0), 1'b0, "R7 new entry absent after long");

    // R8: full unicast table rejects broadcast
    loadFrame(NENT * 3, 1, NENT);
    runAddr(48'hFFFF_FFFF_FFFF, 1'b0, "R8 broadcast rejected");
    for (int i = 0; i < NENT; i++) runAddr(modelTbl[i], 1'b0, "R4 second table");
    runAddr(entryAddr(0, 3), 1'b0, "R4 old table gone");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule